// File: doc/BRIEF.md
# Instruction-Cycle Timer with Write Holdoff

This block is an up-counter paced by the instruction cycle of a small processor core. A phase generator divides the core clock into four quarter phases, Q1 to Q4. One instruction-cycle tick is produced per group of four phases, in the Q4 slot. The tick either advances the count directly or passes through a power-of-two prescaler first.

Software can load the count at any time and read it back with no delay. A load freezes the count for the next two instruction cycles and restarts the prescaler from zero. When the count wraps from all ones to zero, a sticky overflow flag is raised. That flag is sampled once per instruction cycle, at the start of Q1. The sampled copy, gated by a local enable and a global enable, forms the interrupt request.

Top module: `cycle_timer`

## Requirements
- R1: `q_phase` is one-hot. After each clock it moves one position upward: 0001 (Q1), 0010, 0100, 1000 (Q4), then back to 0001. The instruction-cycle tick occurs on the clock edge that leaves Q4. After reset the phase is Q1.
- R2: With `psc_bypass`=1 and no holdoff active, the count rises by exactly one per instruction-cycle tick. With no tick and no load, the count does not change.
- R3: After a load of value N, `rd_data` returns N immediately and stays N through the next two ticks. The third tick after the load gives N+1, and the fourth gives N+2.
- R4: With `psc_bypass`=0, the count advances once every 2^(`psc_sel`+1) ticks, so `psc_sel`=0 gives 1:2 and `psc_sel`=2 gives 1:8. Because a load clears the prescaler, the first increment after the holdoff comes on the 2^(`psc_sel`+1)-th tick after it.
- R5: A wrap of the count from FFh to 00h sets `ovf_flag` on the same edge.
- R6: `ovf_flag` stays set until `ovf_clr` is pulsed. If a clear and a wrap occur in the same cycle, the flag stays set.
- R7: The sampled flag copies `ovf_flag` only on a clock edge taken while in Q1. `irq` is the sampled flag ANDed with `ovf_en` and `glb_en`. A flag cleared during Q1 therefore keeps `irq` high until the next Q1 sampling.
- R8: While `rst` is high, `rd_data`=00h, `ovf_flag`=0, `irq`=0 and `q_phase`=0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one quarter phase per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load strobe for the count |
| wr_data | input | 8 | Value to load |
| psc_bypass | input | 1 | 1: count every tick; 0: use prescaler |
| psc_sel | input | 3 | Prescale exponent, ratio 2^(sel+1) |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_en | input | 1 | Local interrupt enable |
| glb_en | input | 1 | Global interrupt enable |
| rd_data | output | 8 | Current count, combinational |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Gated interrupt request |
| q_phase | output | 4 | One-hot quarter phase, bit 0 = Q1 |

## Verification
The properties assume that `rst` is held for at least one clock, so the phase register starts from Q1. They also assume that `wr_en` and `ovf_clr` are single-cycle levels sampled on the rising edge. The bench drives every input on the falling edge and aligns each load to the start of Q1 by first waiting for Q4. This keeps the cycle counts in R3 and R4 unambiguous. Prescaler settings are changed only just before a load, so a ratio switch never lands in the middle of a prescaler count.

// File: rtl/cyt_pkg.sv
package cyt_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    localparam int PHASE_CNT = 4;

    typedef struct packed {
        logic bypass;
        logic [2:0] sel;
    } psc_cfg_t;

    function automatic phase_e phase_next(input phase_e cur);
        return (cur == PH_Q4) ? PH_Q1 : phase_e'(cur + 2'd1);
    endfunction

    function automatic logic [PHASE_CNT-1:0] phase_onehot(input phase_e cur);
        logic [PHASE_CNT-1:0] v;
        v = '0;
        v[cur] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/cyt_phase_gen.sv
module cyt_phase_gen
    import cyt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    output logic [PHASE_CNT-1:0] phase_oh,
    output logic                 is_q1,
    output logic                 cyc_tick
);
    phase_e ph;

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_Q1;
        else     ph <= phase_next(ph);
    end

    assign phase_oh = phase_onehot(ph);
    assign is_q1    = (ph == PH_Q1);
    assign cyc_tick = (ph == PH_Q4);
endmodule

// File: rtl/cyt_prescaler.sv
module cyt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step_en,
    input  logic             bypass,
    input  logic [SEL_W-1:0] sel,
    output logic             inc
);
    localparam int CNT_W = 2 ** SEL_W;

    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] mask;

    for (genvar g = 0; g < CNT_W; g++) begin : g_mask
        assign mask[g] = (sel >= SEL_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst || clr)   pcnt <= '0;
        else if (step_en) pcnt <= pcnt + 1'b1;
    end

    assign inc = step_en && (bypass || ((pcnt & mask) == mask));
endmodule

// File: rtl/cyt_count_core.sv
module cyt_count_core #(
    parameter int WIDTH    = 8,
    parameter int HOLD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             cyc_tick,
    input  logic             inc,
    output logic [WIDTH-1:0] count,
    output logic             hold_busy,
    output logic             wrap
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst)                          hold_cnt <= '0;
        else if (wr_en)                   hold_cnt <= HW'(HOLD_CYC);
        else if (cyc_tick && hold_busy)   hold_cnt <= hold_cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)        count <= '0;
        else if (wr_en) count <= wr_data;
        else if (inc)   count <= count + 1'b1;
    end

    assign hold_busy = (hold_cnt != '0);
    assign wrap      = inc && !wr_en && (count == {WIDTH{1'b1}});
endmodule

// File: rtl/cyt_irq_unit.sv
module cyt_irq_unit (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic clr,
    input  logic is_q1,
    input  logic en,
    input  logic gen,
    output logic flag,
    output logic smp,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= wrap || (flag && !clr);
    end

    always_ff @(posedge clk) begin
        if (rst)        smp <= 1'b0;
        else if (is_q1) smp <= flag;
    end

    assign req = smp && en && gen;
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
    import cyt_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int SEL_W    = 3,
    parameter int HOLD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             psc_bypass,
    input  logic [SEL_W-1:0] psc_sel,
    input  logic             ovf_clr,
    input  logic             ovf_en,
    input  logic             glb_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             ovf_flag,
    output logic             irq,
    output logic [3:0]       q_phase
);
    logic is_q1;
    logic cyc_tick;
    logic hold_act;
    logic step_en;
    logic cnt_inc;
    logic wrap;
    logic flag_smp;

    cyt_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .phase_oh (q_phase),
        .is_q1    (is_q1),
        .cyc_tick (cyc_tick)
    );

    assign step_en = cyc_tick && !hold_act && !wr_en;

    cyt_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .clr     (wr_en),
        .step_en (step_en),
        .bypass  (psc_bypass),
        .sel     (psc_sel),
        .inc     (cnt_inc)
    );

    cyt_count_core #(.WIDTH(WIDTH), .HOLD_CYC(HOLD_CYC)) u_core (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cyc_tick  (cyc_tick),
        .inc       (cnt_inc),
        .count     (rd_data),
        .hold_busy (hold_act),
        .wrap      (wrap)
    );

    cyt_irq_unit u_irq (
        .clk  (clk),
        .rst  (rst),
        .wrap (wrap),
        .clr  (ovf_clr),
        .is_q1(is_q1),
        .en   (ovf_en),
        .gen  (glb_en),
        .flag (ovf_flag),
        .smp  (flag_smp),
        .req  (irq)
    );
endmodule

// File: rtl/cyt_checker.sv
module cyt_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             ovf_clr,
    input logic             ovf_en,
    input logic             glb_en,
    input logic [WIDTH-1:0] rd_data,
    input logic             ovf_flag,
    input logic             irq,
    input logic [3:0]       q_phase,
    input logic             flag_smp,
    input logic             hold_act
);
    p_phase_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(q_phase) == 1);

    p_phase_order_r1: assert property (@(posedge clk) disable iff (rst)
        q_phase[0] |=> q_phase[1]);

    p_count_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !q_phase[3]) |=> $stable(rd_data));

    p_hold_freeze_r3: assert property (@(posedge clk) disable iff (rst)
        (hold_act && !wr_en) |=> $stable(rd_data));

    p_wrap_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_data == '0 && $past(rd_data) == {WIDTH{1'b1}} && !$past(wr_en)) |-> ovf_flag);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_sample_q1_r7: assert property (@(posedge clk) disable iff (rst)
        !q_phase[0] |=> $stable(flag_smp));

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ovf_en && glb_en && flag_smp));
endmodule

bind cycle_timer cyt_checker #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_cycle_timer.sv
module test_cycle_timer;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       psc_bypass;
    logic [2:0] psc_sel;
    logic       ovf_clr;
    logic       ovf_en;
    logic       glb_en;
    logic [7:0] rd_data;
    logic       ovf_flag;
    logic       irq;
    logic [3:0] q_phase;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cycle_timer i_cycle_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .psc_bypass(psc_bypass), .psc_sel(psc_sel), .ovf_clr(ovf_clr),
        .ovf_en(ovf_en), .glb_en(glb_en), .rd_data(rd_data),
        .ovf_flag(ovf_flag), .irq(irq), .q_phase(q_phase)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // leaves the bench at a falling edge inside Q1, one tick just taken
    task automatic align_q1();
        @(negedge clk);
        while (!q_phase[3]) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic step(input int n);
        repeat (4 * n) @(negedge clk);
    endtask

    // load at Q1; returns one instruction cycle later, again in Q1
    task automatic load(input logic [7:0] v);
        align_q1();
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R8 count", rd_data, 0);
        check("R8 flag", ovf_flag, 0);
        check("R8 irq", irq, 0);
        check("R8 phase", q_phase, 1);
    endtask

    task automatic t_phase();
        align_q1();
        for (int i = 0; i < 8; i++) begin
            check("R1 phase order", q_phase, 1 << (i % 4));
            @(negedge clk);
        end
    endtask

    task automatic t_holdoff();
        load(8'h40);
        check("R3 first cycle", rd_data, 8'h40);
        step(1); check("R3 second cycle", rd_data, 8'h40);
        step(1); check("R3 third cycle", rd_data, 8'h41);
        step(1); check("R3 fourth cycle", rd_data, 8'h42);
    endtask

    task automatic t_bypass();
        for (int k = 1; k <= 5; k++) begin
            step(1);
            check("R2 unit step", rd_data, 8'h42 + k);
        end
        repeat (3) @(negedge clk);
        check("R2 no tick no change", rd_data, 8'h47);
        @(negedge clk);
    endtask

    task automatic t_prescale(input logic [2:0] sel, input logic [7:0] n);
        int ratio;
        ratio = 2 << sel;
        psc_bypass = 1'b0; psc_sel = sel;
        load(n);
        step(1);
        check("R4 holdoff", rd_data, n);
        for (int k = 1; k <= ratio; k++) begin
            step(1);
            check("R4 ratio", rd_data, (k < ratio) ? n : n + 8'd1);
        end
        step(ratio);
        check("R4 second period", rd_data, n + 8'd2);
        psc_bypass = 1'b1;
    endtask

    task automatic t_wrap();
        ovf_en = 1'b1; glb_en = 1'b1;
        load(8'hFE);
        step(1); check("R3 hold FE", rd_data, 8'hFE);
        step(1); check("R2 reach FF", rd_data, 8'hFF);
        check("R5 no flag yet", ovf_flag, 0);
        step(1);
        check("R5 wrapped", rd_data, 0);
        check("R5 flag set", ovf_flag, 1);
        check("R7 not sampled yet", irq, 0);
        @(negedge clk);
        check("R7 sampled at Q1", irq, 1);
        repeat (3) @(negedge clk);
        step(2);
        check("R6 sticky", ovf_flag, 1);
    endtask

    task automatic t_gate();
        glb_en = 1'b0; #1;
        check("R7 global gate", irq, 0);
        glb_en = 1'b1; ovf_en = 1'b0; #1;
        check("R7 local gate", irq, 0);
        ovf_en = 1'b1; #1;
        check("R7 both enabled", irq, 1);
    endtask

    task automatic t_clear();
        align_q1();
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check("R6 cleared", ovf_flag, 0);
        check("R7 held until next Q1", irq, 1);
        step(1);
        check("R7 drops after Q1", irq, 0);
    endtask

    task automatic t_collide();
        load(8'hFF);
        step(1);
        check("R3 hold FF", rd_data, 8'hFF);
        repeat (3) @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check("R5 wrap on clear", rd_data, 0);
        check("R6 set wins over clear", ovf_flag, 1);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; psc_bypass = 1'b1;
        psc_sel = '0; ovf_clr = 1'b0; ovf_en = 1'b0; glb_en = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_phase();
        t_holdoff();
        t_bypass();
        t_prescale(3'd0, 8'h10);
        t_prescale(3'd2, 8'h80);
        t_wrap();
        t_gate();
        t_clear();
        t_collide();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule